// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Acknowledge Handshake

This block gathers a set of peripheral interrupt lines and drives one interrupt request toward a processor. Each line is either edge-triggered or level-sensitive, chosen per line by a parameter. A rising edge on an edge-triggered line sets a sticky pending bit. A level-sensitive line is used as it is, with no latch, and its peripheral is expected to hold it high until software clears the cause.

Every cycle, a fixed-priority picker chooses the lowest-numbered unmasked request and registers it as the next candidate. The handshake state machine has two states:
- `ST_IDLE` moves to `ST_SIGNAL` on the *launch* transition. This happens when a candidate is valid. On the same edge, the candidate's number is copied into the source register.
- `ST_SIGNAL` holds until the *agree* transition, which is a write of 1 to the agreement bit. It then returns to `ST_IDLE`.

While the request is up, reading the source register clears that line's pending bit, and the request stays up. A simple register bus gives access to the mask, the source register and the agreement bit.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` is low, the mask register reads all ones and the source register reads zero.
- R2: On an edge-triggered line, a 0-to-1 transition sets a sticky pending bit. A line held high does not set the bit again after that bit is cleared.
- R3: A level-sensitive line requests only while it is high. A level request that goes away while masked leaves nothing behind.
- R4: When several requests are eligible, the lowest line number wins.
- R5: Address 0 is the mask register. Bit i = 1 keeps line i out of arbitration, and a masked edge remains pending until unmasked.
- R6: `irq_o` rises one clock after the controller is idle with a valid registered candidate. The candidate's number is loaded into the source register (address 1, low bits) on that same edge.
- R7: While `irq_o` is high, the source register does not change, even when new higher-priority requests arrive.
- R8: A read of address 1 while `irq_o` is high clears the pending bit of the line held in the source register, and `irq_o` stays high.
- R9: A write with bit 0 = 1 to address 2 lowers `irq_o` on the next clock. A write with bit 0 = 0 has no effect. Reading address 2 returns `irq_o` in bit 0.
- R10: After the agreement write, a request that is still eligible raises `irq_o` again and loads the source register with the new winner.
- R11: Reading address 1 while `irq_o` is low returns the last captured number and leaves pending bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | NUM_LINES | Peripheral interrupt lines |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register address (0 mask, 1 source, 2 control) |
| bus_wdata_i | input | NUM_LINES | Write data |
| bus_rdata_o | output | NUM_LINES | Read data for the addressed register (combinational) |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that software reads the source register at least one cycle before the agreement write. They also assume that a level-sensitive line is dropped at least one cycle before that write. Under these two conditions the registered candidate is never stale when the controller re-arms. The stimulus always puts a read, or a level drop followed by an idle cycle, ahead of each acknowledge. Bus accesses last one cycle each and are separated by idle cycles.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_SIGNAL = 1'b1
    } irqc_state_e;

    localparam logic [1:0] ADDR_MASK = 2'd0;
    localparam logic [1:0] ADDR_SRC  = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

endpackage

// File: rtl/irqc_edge_latch.sv
module irqc_edge_latch #(
    parameter int              N          = 8,
    parameter logic [N-1:0]    EDGE_LINES = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] req_o
);

    for (genvar g = 0; g < N; g++) begin : g_line
        if (EDGE_LINES[g]) begin : g_edge
            logic prev_q;
            logic pend_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prev_q <= 1'b0;
                    pend_q <= 1'b0;
                end else begin
                    prev_q <= line_i[g];
                    // a fresh edge wins over a clear in the same cycle
                    pend_q <= (pend_q & ~clr_i[g]) | (line_i[g] & ~prev_q);
                end
            end
            assign req_o[g] = pend_q;
        end else begin : g_level
            logic unused_clr;
            assign unused_clr = clr_i[g];
            assign req_o[g]   = line_i[g];
        end
    end

endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
    parameter int N    = 8,
    parameter int ID_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req_i,
    input  logic [N-1:0]    mask_i,
    output logic            nxt_valid_o,
    output logic [ID_W-1:0] nxt_id_o
);

    logic [N-1:0]    eligible;
    logic            hit;
    logic [ID_W-1:0] hit_id;

    assign eligible = req_i & ~mask_i;

    always_comb begin
        hit    = 1'b0;
        hit_id = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                hit    = 1'b1;
                hit_id = ID_W'(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nxt_valid_o <= 1'b0;
            nxt_id_o    <= '0;
        end else begin
            nxt_valid_o <= hit;
            nxt_id_o    <= hit_id;
        end
    end

endmodule

// File: rtl/irqc_hs_fsm.sv
module irqc_hs_fsm
    import irqc_pkg::*;
#(
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cand_valid_i,
    input  logic [ID_W-1:0] cand_id_i,
    input  logic            agree_i,
    output logic            irq_o,
    output logic [ID_W-1:0] src_o
);

    irqc_state_e state_q, state_d;
    logic        launch;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cand_valid_i) state_d = ST_SIGNAL;
            ST_SIGNAL: if (agree_i)      state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_o  = (state_q == ST_SIGNAL);
        launch = (state_q == ST_IDLE) && cand_valid_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      src_o <= '0;
        else if (launch) src_o <= cand_id_i;
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int                     NUM_LINES  = 8,
    parameter logic [NUM_LINES-1:0]   EDGE_LINES = 8'h0F,
    localparam int                    ID_W       = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines_i,
    input  logic                 bus_sel_i,
    input  logic                 bus_wr_i,
    input  logic [1:0]           bus_addr_i,
    input  logic [NUM_LINES-1:0] bus_wdata_i,
    output logic [NUM_LINES-1:0] bus_rdata_o,
    output logic                 irq_o
);

    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] req;
    logic [NUM_LINES-1:0] clr;
    logic                 nxt_valid;
    logic [ID_W-1:0]      nxt_id;
    logic [ID_W-1:0]      src_q;
    logic                 wr_mask, rd_src, agree;

    assign wr_mask = bus_sel_i &  bus_wr_i & (bus_addr_i == ADDR_MASK);
    assign rd_src  = bus_sel_i & ~bus_wr_i & (bus_addr_i == ADDR_SRC);
    assign agree   = bus_sel_i &  bus_wr_i & (bus_addr_i == ADDR_CTRL) & bus_wdata_i[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '1;
        else if (wr_mask) mask_q <= bus_wdata_i;
    end

    assign clr = (rd_src && irq_o) ? (NUM_LINES'(1) << src_q) : '0;

    irqc_edge_latch #(.N(NUM_LINES), .EDGE_LINES(EDGE_LINES)) u_latch (
        .clk(clk), .rst_n(rst_n), .line_i(irq_lines_i), .clr_i(clr), .req_o(req)
    );

    irqc_prio_pick #(.N(NUM_LINES), .ID_W(ID_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .req_i(req), .mask_i(mask_q),
        .nxt_valid_o(nxt_valid), .nxt_id_o(nxt_id)
    );

    irqc_hs_fsm #(.ID_W(ID_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cand_valid_i(nxt_valid), .cand_id_i(nxt_id),
        .agree_i(agree), .irq_o(irq_o), .src_o(src_q)
    );

    always_comb begin
        bus_rdata_o = '0;
        unique case (bus_addr_i)
            ADDR_MASK: bus_rdata_o = mask_q;
            ADDR_SRC:  bus_rdata_o[ID_W-1:0] = src_q;
            ADDR_CTRL: bus_rdata_o[0] = irq_o;
            default:   bus_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int N    = 8,
    parameter int ID_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            irq_o,
    input logic            nxt_valid,
    input logic [ID_W-1:0] nxt_id,
    input logic [ID_W-1:0] src_q,
    input logic            bus_sel_i,
    input logic            bus_wr_i,
    input logic [1:0]      bus_addr_i,
    input logic [N-1:0]    bus_wdata_i
);

    logic ack_seen;
    assign ack_seen = bus_sel_i && bus_wr_i && (bus_addr_i == 2'd2) && bus_wdata_i[0];

    assert_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && nxt_valid) |=> irq_o);

    assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && nxt_valid) |=> (src_q == $past(nxt_id)));

    assert_src_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> (!irq_o || $stable(src_q)));

    assert_stay_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_seen) |=> irq_o);

    assert_agree_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_seen) |=> !irq_o);

endmodule

bind prio_irq_ctrl irqc_checker #(.N(NUM_LINES), .ID_W(ID_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .nxt_valid(nxt_valid),
    .nxt_id(nxt_id), .src_q(src_q), .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam logic [N-1:0] EDGE = 8'h0F;
    localparam int WATCHDOG   = 5000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] lines = '0;
    logic         sel = 1'b0, wr = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic         irq;

    int checks = 0, errors = 0, cycles = 0;
    string cur_req = "R1";

    // behavioural reference state
    logic [N-1:0] m_pend, m_prev, m_mask;
    logic         m_irq, m_nv;
    int           m_src, m_nid;

    prio_irq_ctrl #(.NUM_LINES(N), .EDGE_LINES(EDGE)) u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_lines_i(lines), .bus_sel_i(sel),
        .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_rdata();
        case (addr)
            2'd0: return int'(m_mask);
            2'd1: return m_src;
            2'd2: return int'(m_irq);
            default: return 0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pend = '0; m_prev = '0; m_mask = '1;
            m_irq = 1'b0; m_src = 0; m_nv = 1'b0; m_nid = 0;
        end else begin
            bit rd_s, ack;
            int best;
            logic [N-1:0] np;
            rd_s = sel && !wr && addr == 2'd1;
            ack  = sel && wr && addr == 2'd2 && wdata[0];
            best = -1;
            for (int i = N - 1; i >= 0; i--)
                if (((EDGE[i] ? m_pend[i] : lines[i]) && !m_mask[i])) best = i;
            for (int i = 0; i < N; i++) begin
                np[i] = 1'b0;
                if (EDGE[i]) begin
                    np[i] = m_pend[i];
                    if (rd_s && m_irq && m_src == i) np[i] = 1'b0;
                    if (lines[i] && !m_prev[i]) np[i] = 1'b1;
                end
            end
            if (!m_irq) begin
                if (m_nv) begin m_irq = 1'b1; m_src = m_nid; end
            end else if (ack) m_irq = 1'b0;
            if (sel && wr && addr == 2'd0) m_mask = wdata;
            m_prev = lines;
            m_pend = np;
            m_nv   = (best >= 0);
            m_nid  = (best >= 0) ? best : 0;
        end
    end

    // every-cycle comparison a quarter period after the rising edge
    always @(posedge clk) begin
        cycles++;
        #(CLK_PERIOD/4);
        if (rst_n) begin
            chk(irq === m_irq, {cur_req, " irq"}, int'(irq), int'(m_irq));
            chk(int'(rdata) == exp_rdata(), {cur_req, " rdata"}, int'(rdata), exp_rdata());
        end
        if (cycles > WATCHDOG) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus(input bit w, input logic [1:0] a, input logic [N-1:0] d);
        @(negedge clk); sel = 1'b1; wr = w; addr = a; wdata = d;
        @(negedge clk); sel = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    task automatic pulse(input int line);
        @(negedge clk); lines[line] = 1'b1;
        @(negedge clk); lines[line] = 1'b0;
    endtask

    // probe at the next quarter-past-edge point, leaving addr at a
    task automatic look(input logic [1:0] a);
        @(negedge clk); addr = a;
        @(posedge clk); #(CLK_PERIOD/4);
    endtask

    initial begin
        idle(2); rst_n = 1'b1;
        // R1 reset state
        cur_req = "R1";
        look(2'd2); chk(irq == 1'b0, "R1 irq low", int'(irq), 0);
        look(2'd0); chk(rdata == '1, "R1 mask", int'(rdata), 'hFF);
        look(2'd1); chk(rdata == '0, "R1 src", int'(rdata), 0);

        // R2 R6 edge line fires
        cur_req = "R6";
        bus(1, 2'd0, '0);
        pulse(2); idle(4);
        look(2'd1); chk(irq && rdata == 2, "R6 src after edge R2", int'(rdata), 2);
        // R7 higher priority while active
        cur_req = "R7";
        pulse(0); idle(3);
        look(2'd1); chk(rdata == 2, "R7 src held", int'(rdata), 2);
        // R8 read clears pending, irq stays
        cur_req = "R8";
        bus(0, 2'd1, '0); idle(2);
        chk(irq == 1'b1, "R8 irq stays", int'(irq), 1);
        // R9 / R10
        cur_req = "R10";
        bus(1, 2'd2, 8'h01); idle(3);
        look(2'd1); chk(irq && rdata == 0, "R10 reassert with line 0", int'(rdata), 0);
        bus(0, 2'd1, '0); bus(1, 2'd2, 8'h01); idle(3);
        chk(irq == 1'b0, "R9 idle after ack", int'(irq), 0);

        // R9 write 0 ignored, level line R3
        cur_req = "R9";
        @(negedge clk); lines[5] = 1'b1; idle(3);
        bus(1, 2'd2, 8'h00); idle(2);
        look(2'd2); chk(rdata[0] == 1'b1, "R9 zero write ignored", int'(rdata), 1);
        cur_req = "R3";
        @(negedge clk); lines[5] = 1'b0; idle(2);
        bus(1, 2'd2, 8'h01); idle(3);
        chk(irq == 1'b0, "R3 level gone no refire", int'(irq), 0);

        // R4 priority between level lines, R10 follow-up
        cur_req = "R4";
        @(negedge clk); lines[4] = 1'b1; lines[7] = 1'b1; idle(3);
        look(2'd1); chk(rdata == 4, "R4 lowest wins", int'(rdata), 4);
        @(negedge clk); lines[4] = 1'b0; idle(2);
        bus(1, 2'd2, 8'h01); idle(3);
        look(2'd1); chk(irq && rdata == 7, "R10 next winner", int'(rdata), 7);
        @(negedge clk); lines[7] = 1'b0; idle(2);
        bus(1, 2'd2, 8'h01); idle(3);

        // R5 masked edge stays pending
        cur_req = "R5";
        bus(1, 2'd0, 8'h02); pulse(1); idle(4);
        chk(irq == 1'b0, "R5 masked no irq", int'(irq), 0);
        bus(1, 2'd0, 8'h00); idle(3);
        look(2'd1); chk(irq && rdata == 1, "R5 unmasked fires", int'(rdata), 1);
        bus(0, 2'd1, '0); bus(1, 2'd2, 8'h01); idle(3);

        // R3 masked level leaves nothing
        cur_req = "R3";
        bus(1, 2'd0, 8'h10);
        @(negedge clk); lines[4] = 1'b1; idle(2);
        @(negedge clk); lines[4] = 1'b0; idle(1);
        bus(1, 2'd0, 8'h00); idle(3);
        chk(irq == 1'b0, "R3 no latch on level", int'(irq), 0);

        // R2 held-high edge line does not retrigger
        cur_req = "R2";
        @(negedge clk); lines[3] = 1'b1; idle(4);
        look(2'd1); chk(irq && rdata == 3, "R2 held edge fires", int'(rdata), 3);
        bus(0, 2'd1, '0); bus(1, 2'd2, 8'h01); idle(4);
        chk(irq == 1'b0, "R2 no retrigger", int'(irq), 0);
        @(negedge clk); lines[3] = 1'b0; idle(1);

        // R11 idle read has no side effect
        cur_req = "R11";
        bus(1, 2'd0, 8'h08); pulse(3); idle(2);
        bus(0, 2'd1, '0);
        look(2'd1); chk(rdata == 3 && !irq, "R11 idle read value", int'(rdata), 3);
        bus(1, 2'd0, 8'h00); idle(3);
        look(2'd1); chk(irq && rdata == 3, "R11 pending kept", int'(rdata), 3);
        bus(0, 2'd1, '0); bus(1, 2'd2, 8'h01); idle(4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule